// File: doc/BRIEF.md
# Overcurrent Protection Timing Sequencer

This block decides how a switching regulator's controller reacts when its current-limit comparator fires. Each PWM period is marked by a one-clock `tick`. The comparator flag and the raw high-side request come in from neighbouring logic. The block returns a gated high-side request, a latched shutdown flag and a power-good flag, and all three are registered.

The first comparator trip seen on a tick, while the block is idle, starts a sixteen-tick protection period. That tick counts as period cycle 1. Cycles 1 to 8 form the first window, where overcurrent only causes pulses to be skipped. Cycles 9 to 16 form the second window. Overcurrent on any tick in the second window latches the controller off. This applies whether the fault is new or has continued from the first window, and it includes cycle 16. If the second window passes with no overcurrent, the block returns to idle. The next trip then opens a new period.

Only a synchronous reset or a low phase on `enable` clears the latch. While `enable` is low, every output is held off and all state is cleared. The window length is the parameter `WIN_LEN`, with a default of 8 and a minimum of 2.

Top module: `oc_guard`

## Requirements
- R1: While enabled, not shut down and `ocFlag` low, `gateReq` equals the `pwmReq` of the previous clock, and `pwrGood` is 1.
- R2: On any clock where `ocFlag` is 1, `gateReq` is 0 on the next clock (pulse skipping), on tick and non-tick clocks alike.
- R3: Overcurrent on ticks in period cycles 1 to 8 never asserts `shutdown`. The tick of the first trip is cycle 1.
- R4: Overcurrent on a tick in period cycles 9 to 16 sets `shutdown` to 1 and `pwrGood` to 0 on the next clock. `gateReq` stays 0 for as long as `shutdown` is 1.
- R5: If no overcurrent occurs on the ticks of cycles 9 to 16, the block returns to idle. A trip on a later tick starts a new period, and that tick is its cycle 1.
- R6: Once `shutdown` is 1, it stays 1 whatever `tick`, `ocFlag` and `pwmReq` do, until `enable` goes low or `rst` is asserted.
- R7: While `enable` is low, `gateReq`, `pwrGood` and `shutdown` are 0 from the next clock on. After `enable` rises again, the block starts from idle and `pwrGood` is 1 on the clock after the rise.
- R8: Only clocks with `tick` at 1 advance the period or sample the comparator for the windows. Clocks without a tick never cause a latch.
- R9: A clock with `rst` at 1 clears all state and sets `gateReq`, `pwrGood` and `shutdown` to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Controller enable, active high; a low phase clears the latch |
| tick | input | 1 | One-clock strobe, once per PWM period |
| ocFlag | input | 1 | Overcurrent comparator output, 1 = over threshold |
| pwmReq | input | 1 | Raw high-side on request from the modulator |
| gateReq | output | 1 | Gated high-side request, registered |
| shutdown | output | 1 | Latched-off flag, registered |
| pwrGood | output | 1 | Power-good flag, registered |

## Verification
A wrong period counter shows up in the tick after the one where the latch decision is due. A period that ends one tick early lets overcurrent on cycle 16 pass with no shutdown. A period that ends one tick late turns a trip on cycle 17 into a latch, and counting non-tick clocks makes a later cycle-9 fault look like a new trip. A wrong state register, such as a lost latch or a missed return to idle, shows on `shutdown` and `pwrGood` one clock after the tick that decides. The bench therefore probes cycles 8, 9, 16 and 17 directly, and it runs the period with long gaps between ticks.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_WATCH = 2'd2,
    ST_LATCH = 2'd3
  } ocState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic cntLoad;   // start a period: count becomes 1
    logic cntInc;    // one more tick consumed
    logic cntClr;    // period over or aborted
    logic latchNext; // state after this edge is the latch
    logic runNext;   // controller enabled after this edge
  } ctlStrobe_t;

endpackage

// File: rtl/oc_guard_ctrl.sv
module oc_guard_ctrl
  import oc_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       tick,
  input  logic       ocFlag,
  input  logic       atWinEnd,
  input  logic       atPeriodEnd,
  output ctlStrobe_t ctl
);

  ocState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    ctl.runNext   = enable;
    if (!enable) begin
      stateNext  = ST_IDLE;
      ctl.cntClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tick && ocFlag) begin
            stateNext   = ST_SKIP;
            ctl.cntLoad = 1'b1;
          end
        end
        ST_SKIP: begin
          if (tick) begin
            ctl.cntInc = 1'b1;
            if (atWinEnd) stateNext = ST_WATCH;
          end
        end
        ST_WATCH: begin
          if (tick) begin
            if (ocFlag) begin
              stateNext  = ST_LATCH;
              ctl.cntClr = 1'b1;
            end else if (atPeriodEnd) begin
              stateNext  = ST_IDLE;
              ctl.cntClr = 1'b1;
            end else begin
              ctl.cntInc = 1'b1;
            end
          end
        end
        ST_LATCH: stateNext = ST_LATCH;
        default:  stateNext = ST_IDLE;
      endcase
    end
    ctl.latchNext = (stateNext == ST_LATCH);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/oc_guard_dp.sv
module oc_guard_dp
  import oc_guard_pkg::*;
#(
  parameter int WIN_LEN = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t ctl,
  input  logic       ocFlag,
  input  logic       pwmReq,
  output logic       atWinEnd,
  output logic       atPeriodEnd,
  output logic       gateReq,
  output logic       shutdown,
  output logic       pwrGood
);

  localparam int PERIOD = 2 * WIN_LEN;
  localparam int CW     = $clog2(PERIOD);

  logic [CW-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (rst || ctl.cntClr) tickCnt <= '0;
    else if (ctl.cntLoad)  tickCnt <= CW'(1);
    else if (ctl.cntInc)   tickCnt <= tickCnt + CW'(1);
  end

  // Count holds the period cycle number of the last consumed tick
  assign atWinEnd    = (tickCnt == CW'(WIN_LEN - 1));
  assign atPeriodEnd = (tickCnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gateReq  <= 1'b0;
      shutdown <= 1'b0;
      pwrGood  <= 1'b0;
    end else begin
      gateReq  <= ctl.runNext && !ctl.latchNext && !ocFlag && pwmReq;
      shutdown <= ctl.latchNext;
      pwrGood  <= ctl.runNext && !ctl.latchNext;
    end
  end

endmodule

// File: rtl/oc_guard.sv
module oc_guard
  import oc_guard_pkg::*;
#(
  parameter int WIN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic ocFlag,
  input  logic pwmReq,
  output logic gateReq,
  output logic shutdown,
  output logic pwrGood
);

  ctlStrobe_t ctl;
  logic       atWinEnd;
  logic       atPeriodEnd;

  oc_guard_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .tick        (tick),
    .ocFlag      (ocFlag),
    .atWinEnd    (atWinEnd),
    .atPeriodEnd (atPeriodEnd),
    .ctl         (ctl)
  );

  oc_guard_dp #(.WIN_LEN(WIN_LEN)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .ocFlag      (ocFlag),
    .pwmReq      (pwmReq),
    .atWinEnd    (atWinEnd),
    .atPeriodEnd (atPeriodEnd),
    .gateReq     (gateReq),
    .shutdown    (shutdown),
    .pwrGood     (pwrGood)
  );

endmodule

// File: rtl/oc_guard_chk.sv
module oc_guard_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic tick,
  input logic ocFlag,
  input logic pwmReq,
  input logic gateReq,
  input logic shutdown,
  input logic pwrGood
);

  p_pass_through_r1: assert property (@(posedge clk) disable iff (rst)
    (enable && !ocFlag && !shutdown) |=> (gateReq == $past(pwmReq)));

  p_skip_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ocFlag |=> !gateReq);

  p_latched_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> (!pwrGood && !gateReq));

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (shutdown && enable) |=> shutdown);

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!shutdown && !pwrGood && !gateReq));

  p_no_tick_no_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !shutdown) |=> !shutdown);

endmodule

bind oc_guard oc_guard_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .tick     (tick),
  .ocFlag   (ocFlag),
  .pwmReq   (pwmReq),
  .gateReq  (gateReq),
  .shutdown (shutdown),
  .pwrGood  (pwrGood)
);

// File: tb/oc_guard_tb.sv
module oc_guard_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b1;
  logic tick = 1'b0;
  logic ocFlag = 1'b0;
  logic pwmReq = 1'b0;
  logic gateReq, shutdown, pwrGood;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oc_guard u_dut (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick),
    .ocFlag(ocFlag), .pwmReq(pwmReq),
    .gateReq(gateReq), .shutdown(shutdown), .pwrGood(pwrGood)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample 5 ns later
  task automatic step(input logic tk, input logic oc, input logic pwm);
    @(negedge clk);
    tick = tk; ocFlag = oc; pwmReq = pwm;
    @(posedge clk);
    #5;
  endtask

  task automatic cleanTicks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b1);
  endtask

  task automatic rearm();
    @(negedge clk); enable = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk); enable = 1'b1;
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1; enable = 1'b1;
    step(1'b1, 1'b0, 1'b1);
    chk("R9", "gateReq in reset", gateReq, 1'b0);
    chk("R9", "pwrGood in reset", pwrGood, 1'b0);
    chk("R9", "shutdown in reset", shutdown, 1'b0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b0, 1'b1);
    chk("R1", "pwrGood after reset", pwrGood, 1'b1);
    chk("R1", "gateReq after reset", gateReq, 1'b1);
  endtask

  task automatic t_pass();
    logic [5:0] pat = 6'b101101;
    for (int i = 0; i < 6; i++) begin
      step(i[0], 1'b0, pat[i]);
      chk("R1", "gateReq follows pwmReq", gateReq, pat[i]);
    end
  endtask

  task automatic t_window1_and_rearm();
    step(1'b1, 1'b1, 1'b1);                       // cycle 1
    chk("R2", "gate skipped on trip", gateReq, 1'b0);
    for (int c = 2; c <= 8; c++) begin
      step(1'b1, (c == 5), 1'b1);
      chk("R3", "no shutdown in window 1", shutdown, 1'b0);
      if (c == 5) chk("R2", "gate skipped cycle 5", gateReq, 1'b0);
    end
    cleanTicks(8);                                // cycles 9..16
    chk("R5", "no latch after clean window 2", shutdown, 1'b0);
    chk("R1", "gate passes after period", gateReq, 1'b1);
    step(1'b1, 1'b1, 1'b1);                       // cycle 17: new trip
    chk("R5", "cycle 17 trip not latched", shutdown, 1'b0);
    cleanTicks(6);                                // new cycles 2..7
    step(1'b1, 1'b1, 1'b1);                       // new cycle 8
    chk("R5", "new window 1 covers cycle 24", shutdown, 1'b0);
    cleanTicks(8);
    chk("R5", "second period ends idle", pwrGood, 1'b1);
    rearm();
  endtask

  task automatic t_latch_cycle9();
    step(1'b1, 1'b1, 1'b0);
    cleanTicks(7);                                // cycles 2..8
    chk("R3", "cycle 8 still running", shutdown, 1'b0);
    step(1'b1, 1'b1, 1'b1);                       // cycle 9
    chk("R4", "shutdown at cycle 9", shutdown, 1'b1);
    chk("R4", "pwrGood low at cycle 9", pwrGood, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(i[0], 1'b0, 1'b1);
      chk("R6", "latch holds", shutdown, 1'b1);
      chk("R6", "gate off while latched", gateReq, 1'b0);
    end
    @(negedge clk); enable = 1'b0;
    step(1'b1, 1'b0, 1'b1);
    chk("R7", "shutdown cleared by enable low", shutdown, 1'b0);
    chk("R7", "pwrGood low while disabled", pwrGood, 1'b0);
    chk("R7", "gate off while disabled", gateReq, 1'b0);
    @(negedge clk); enable = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    chk("R7", "pwrGood after re-enable", pwrGood, 1'b1);
    chk("R7", "gate after re-enable", gateReq, 1'b1);
  endtask

  task automatic t_latch_cycle16();
    step(1'b1, 1'b1, 1'b0);
    cleanTicks(14);                               // cycles 2..15
    chk("R4", "no latch through cycle 15", shutdown, 1'b0);
    step(1'b1, 1'b1, 1'b1);                       // cycle 16
    chk("R4", "shutdown at cycle 16", shutdown, 1'b1);
    @(negedge clk); rst = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    chk("R9", "reset clears latch", shutdown, 1'b0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b0, 1'b1);
    chk("R9", "pwrGood after reset release", pwrGood, 1'b1);
  endtask

  task automatic t_persist();
    for (int c = 1; c <= 8; c++) step(1'b1, 1'b1, 1'b1);
    chk("R3", "persistent oc, cycle 8 no latch", shutdown, 1'b0);
    chk("R2", "persistent oc gate off", gateReq, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R4", "persistent oc latches at cycle 9", shutdown, 1'b1);
    rearm();
  endtask

  task automatic t_tick_only();
    step(1'b1, 1'b1, 1'b1);                       // cycle 1
    for (int i = 0; i < 30; i++) begin
      step(1'b0, i[1], 1'b1);
      chk("R8", "no latch without tick", shutdown, 1'b0);
      if (i[1]) chk("R2", "gate off on non-tick oc", gateReq, 1'b0);
    end
    cleanTicks(7);                                // cycles 2..8
    step(1'b1, 1'b1, 1'b1);                       // cycle 9
    chk("R8", "only ticks advance period", shutdown, 1'b1);
    rearm();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_window1_and_rearm();
    t_latch_cycle9();
    t_latch_cycle16();
    t_persist();
    t_tick_only();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule